// File: doc/BRIEF.md
# Token Bucket Departure-Time Stamper

This block sits in front of a rank-ordered (push-in, first-out) queue and turns a token-bucket rate limit into a rank. Each arriving packet is given the earliest time at which it may leave, so the queue, when sorted by rank, releases traffic at the configured rate. Bursts up to the configured bucket depth leave at once. Packets are not held back at dequeue. The block stamps them at enqueue and lets the bucket go into debt, so that later packets are pushed further into the future.

The block keeps one signed token count and the time of the last update. For each packet it tops up the bucket by the time elapsed multiplied by the rate and clips the result to the bucket depth. If the packet is larger than the tokens available, it adds the shortfall divided by the rate to the current time, rounding up. It then charges the packet length to the bucket. The rate is a power of two, so both the multiply and the divide are shifts.

Top module: `shaper_rank`

## Requirements
- R1: While reset is asserted, `rank_valid` is 0 and `rank` is 0. After reset the bucket holds `burst` tokens and the last-update time is 0.
- R2: On each accepted packet, the bucket first gains `(now - last) << rate_shift` tokens and is then clipped to at most `burst`.
- R3: When the packet length exceeds the tokens after refill, the rank is `now + ceil((pkt_len - tokens) / 2^rate_shift)`, computed modulo 2^TIME_W.
- R4: When the tokens after refill are at least the packet length, the rank equals `now`.
- R5: After stamping, the packet length is subtracted from the refilled tokens. The count is a TOK_W-bit two's complement value and may go negative. The debt carries over to later packets.
- R6: The last-update time becomes `now` on every accepted packet. Elapsed time is taken modulo 2^TIME_W, so a wrap of `now` refills correctly.
- R7: A packet with `pkt_valid` high at a rising edge gives `rank_valid` high with its rank after that edge, for exactly that cycle. Back-to-back packets each use the state left by the one before.
- R8: A cycle with `pkt_valid` low changes neither the bucket nor the last-update time. It drives `rank_valid` low and leaves `rank` holding its previous value.
- R9: `rate_shift` = k means a rate of 2^k tokens per time unit, for both the refill and the shortfall division. The value may change between packets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | A packet is presented this cycle |
| pkt_len | input | LEN_W | Packet length in tokens |
| now | input | TIME_W | Current time |
| rate_shift | input | SHIFT_W | Rate exponent k (2^k tokens per time unit) |
| burst | input | TOK_W-1 | Bucket depth in tokens |
| rank_valid | output | 1 | Rank output is valid this cycle |
| rank | output | TIME_W | Departure time, used as the queue rank |

## Verification
The hardest states to reach are a deep token debt followed by a long idle gap, and a gap that crosses the wrap of `now`. In the first, the refill must first repay the debt and then be clipped. In the second, the elapsed time is only correct modulo the counter width. The stimulus drives the bucket negative with packets at one instant, then jumps `now` far ahead. It later places a packet just below the top of the time range and the next one just after the wrap. It also raises `rate_shift` to its largest value over a large gap, which exercises the widest intermediate sum. A run of idle cycles followed by a packet at an unchanged time shows at the rank that the state held still.

// File: rtl/shaper_rank_pkg.sv
// Package: default widths shared by the departure-time stamper and its checker.
// Assumes LEN_W < TOK_W and TOK_W + 2 <= TIME_W.
package shaper_rank_pkg;
    parameter int TIME_W_D  = 32;
    parameter int TOK_W_D   = 24;
    parameter int LEN_W_D   = 16;
    parameter int SHIFT_W_D = 4;
endpackage

// File: rtl/shaper_refill.sv
// Module: shaper_refill
// Adds elapsed-time credit to the bucket and clips the result at the depth.
// Assumes elapsed time wraps modulo 2^TIME_W. The intermediate sum is wide
// enough for the largest shift, so it never overflows.
module shaper_refill #(
    parameter int TIME_W  = 32,
    parameter int TOK_W   = 24,
    parameter int SHIFT_W = 4
) (
    input  logic signed [TOK_W-1:0]   tok_cur,
    input  logic        [TIME_W-1:0]  last_t,
    input  logic        [TIME_W-1:0]  now,
    input  logic        [SHIFT_W-1:0] rate_shift,
    input  logic        [TOK_W-2:0]   burst,
    output logic signed [TOK_W-1:0]   tok_fill
);
    localparam int MAX_SH = (1 << SHIFT_W) - 1;
    localparam int SUM_W  = TIME_W + MAX_SH + 2;

    logic        [TIME_W-1:0] elapsed;
    logic        [SUM_W-1:0]  gain_u;
    logic signed [SUM_W-1:0]  sum_s;
    logic signed [SUM_W-1:0]  cap_s;

    // Refill: credit = elapsed << k, then clip to the bucket depth.
    always_comb begin
        elapsed  = now - last_t;
        gain_u   = {{(SUM_W-TIME_W){1'b0}}, elapsed} << rate_shift;
        sum_s    = $signed({{(SUM_W-TOK_W){tok_cur[TOK_W-1]}}, tok_cur}) + $signed(gain_u);
        cap_s    = $signed({{(SUM_W-TOK_W+1){1'b0}}, burst});
        tok_fill = (sum_s > cap_s) ? cap_s[TOK_W-1:0] : sum_s[TOK_W-1:0];
    end
endmodule

// File: rtl/shaper_delay.sv
// Module: shaper_delay
// Turns a token shortfall into a departure time by dividing it by 2^k,
// rounding up, and charges the packet to the bucket.
// Assumes the refilled count plus the packet length fits in TOK_W+1 bits.
module shaper_delay #(
    parameter int TIME_W  = 32,
    parameter int TOK_W   = 24,
    parameter int LEN_W   = 16,
    parameter int SHIFT_W = 4
) (
    input  logic signed [TOK_W-1:0]   tok_fill,
    input  logic        [LEN_W-1:0]   pkt_len,
    input  logic        [TIME_W-1:0]  now,
    input  logic        [SHIFT_W-1:0] rate_shift,
    output logic        [TIME_W-1:0]  send_t,
    output logic signed [TOK_W-1:0]   tok_after
);
    localparam int DIF_W = TOK_W + 1;
    localparam int RND_W = DIF_W + 1;

    logic signed [DIF_W-1:0] short_s;
    logic        [RND_W-1:0] round_mask;
    logic        [RND_W-1:0] wait_t;
    logic signed [TOK_W-1:0] len_s;

    // Shortfall, divided by the rate with round-up, then added to the current time.
    always_comb begin
        len_s      = $signed({{(TOK_W-LEN_W){1'b0}}, pkt_len});
        short_s    = $signed({len_s[TOK_W-1], len_s}) - $signed({tok_fill[TOK_W-1], tok_fill});
        round_mask = (RND_W'(1) << rate_shift) - RND_W'(1);
        if (short_s > 0)
            wait_t = ({1'b0, short_s} + round_mask) >> rate_shift;
        else
            wait_t = '0;
        send_t    = now + TIME_W'(wait_t);
        tok_after = tok_fill - len_s;
    end
endmodule

// File: rtl/shaper_rank.sv
// Module: shaper_rank (top)
// Token-bucket departure-time stamper: one packet per cycle, rank registered
// one cycle later. It holds the signed token count and the last-update time.
// Assumes synchronous active-low reset and burst < 2^(TOK_W-1).
module shaper_rank
    import shaper_rank_pkg::*;
#(
    parameter int TIME_W  = TIME_W_D,
    parameter int TOK_W   = TOK_W_D,
    parameter int LEN_W   = LEN_W_D,
    parameter int SHIFT_W = SHIFT_W_D
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pkt_valid,
    input  logic [LEN_W-1:0]   pkt_len,
    input  logic [TIME_W-1:0]  now,
    input  logic [SHIFT_W-1:0] rate_shift,
    input  logic [TOK_W-2:0]   burst,
    output logic               rank_valid,
    output logic [TIME_W-1:0]  rank
);
    logic signed [TOK_W-1:0]  tok_q;
    logic        [TIME_W-1:0] last_q;
    logic signed [TOK_W-1:0]  tok_fill;
    logic signed [TOK_W-1:0]  tok_after;
    logic        [TIME_W-1:0] send_t;

    shaper_refill #(.TIME_W(TIME_W), .TOK_W(TOK_W), .SHIFT_W(SHIFT_W)) u_refill (
        .tok_cur    (tok_q),
        .last_t     (last_q),
        .now        (now),
        .rate_shift (rate_shift),
        .burst      (burst),
        .tok_fill   (tok_fill)
    );

    shaper_delay #(.TIME_W(TIME_W), .TOK_W(TOK_W), .LEN_W(LEN_W), .SHIFT_W(SHIFT_W)) u_delay (
        .tok_fill   (tok_fill),
        .pkt_len    (pkt_len),
        .now        (now),
        .rate_shift (rate_shift),
        .send_t     (send_t),
        .tok_after  (tok_after)
    );

    // Bucket state: fill on reset, update only on an accepted packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_q  <= $signed({1'b0, burst});
            last_q <= '0;
        end else if (pkt_valid) begin
            tok_q  <= tok_after;
            last_q <= now;
        end
    end

    // Output register: strobe for one cycle, rank held between packets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rank_valid <= 1'b0;
            rank       <= '0;
        end else begin
            rank_valid <= pkt_valid;
            if (pkt_valid)
                rank <= send_t;
        end
    end
endmodule

// File: rtl/shaper_rank_chk.sv
// Module: shaper_rank_chk
// Timing and bucket-bound properties of the stamper, attached by bind.
module shaper_rank_chk #(
    parameter int TIME_W  = 32,
    parameter int TOK_W   = 24,
    parameter int LEN_W   = 16,
    parameter int SHIFT_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pkt_valid,
    input logic [LEN_W-1:0]   pkt_len,
    input logic [TIME_W-1:0]  now,
    input logic [SHIFT_W-1:0] rate_shift,
    input logic [TOK_W-2:0]   burst,
    input logic               rank_valid,
    input logic [TIME_W-1:0]  rank,
    input logic signed [TOK_W-1:0] tok_q
);
    localparam logic [TIME_W-1:0] MAX_WAIT = TIME_W'(1) << (TOK_W + 1);

    // R7: the strobe follows the packet by one cycle.
    assert_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> rank_valid);
    // R8: no packet, no strobe.
    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |=> !rank_valid);
    // R8: an idle cycle leaves the bucket untouched.
    assert_tok_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |=> $stable(tok_q));
    // R8: the rank holds while no strobe is given.
    assert_rank_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rank_valid |-> $stable(rank));
    // R3/R4: the rank never lies before the packet time, and lies within the largest wait.
    assert_rank_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> ((rank - $past(now)) <= MAX_WAIT));
    // R2/R5: the charged bucket never exceeds depth minus the packet just charged.
    assert_bucket_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> ($signed({tok_q[TOK_W-1], tok_q}) + $signed({1'b0, {(TOK_W-LEN_W){1'b0}}, $past(pkt_len)})
                       <= $signed({2'b00, $past(burst)})));
endmodule

bind shaper_rank shaper_rank_chk #(
    .TIME_W(TIME_W), .TOK_W(TOK_W), .LEN_W(LEN_W), .SHIFT_W(SHIFT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .now(now), .rate_shift(rate_shift), .burst(burst),
    .rank_valid(rank_valid), .rank(rank), .tok_q(tok_q)
);

// File: tb/sim_shaper_rank.sv
// Bench: directed scenarios, one task each, with a reference bucket model.
module sim_shaper_rank;
    localparam int TIME_W = 32;
    localparam int TOK_W  = 24;
    localparam int LEN_W  = 16;
    localparam int SHIFT_W = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               pkt_valid = 1'b0;
    logic [LEN_W-1:0]   pkt_len = '0;
    logic [TIME_W-1:0]  now = '0;
    logic [SHIFT_W-1:0] rate_shift = '0;
    logic [TOK_W-2:0]   burst = '0;
    logic               rank_valid;
    logic [TIME_W-1:0]  rank;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    longint m_tok;
    longint m_last;
    longint m_rank;

    shaper_rank #(.TIME_W(TIME_W), .TOK_W(TOK_W), .LEN_W(LEN_W), .SHIFT_W(SHIFT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
        .now(now), .rate_shift(rate_shift), .burst(burst),
        .rank_valid(rank_valid), .rank(rank)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as one failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model of one accepted packet, written from R2 to R6.
    function automatic longint model_pkt(input longint len, input longint t);
        longint el;
        longint f;
        longint sh;
        longint d;
        longint k;
        k  = longint'(rate_shift);
        el = (t - m_last) & 64'hFFFF_FFFF;
        f  = m_tok + (el << k);
        if (f > longint'(burst)) f = longint'(burst);
        sh = len - f;
        d  = (sh > 0) ? ((sh + (64'sd1 << k) - 1) >>> k) : 0;
        m_tok  = f - len;
        m_last = t;
        return (t + d) & 64'hFFFF_FFFF;
    endfunction

    // Present one packet, sample after the edge, and compare with the model and the hand value.
    task automatic send_pkt(input int len, input longint t, input longint hand, input string req);
        @(negedge clk);
        pkt_valid = 1'b1;
        pkt_len   = LEN_W'(len);
        now       = TIME_W'(t);
        m_rank    = model_pkt(len, t);
        @(negedge clk);
        pkt_valid = 1'b0;
        check(rank_valid == 1'b1, {req, " strobe R7"}, longint'(rank_valid), 1);
        check(longint'(rank) == m_rank, req, longint'(rank), m_rank);
        if (hand >= 0)
            check(longint'(rank) == hand, {req, " hand"}, longint'(rank), hand);
    endtask

    task automatic t_reset;
        rate_shift = 4'd2;
        burst      = 23'd1000;
        repeat (3) @(negedge clk);
        check(rank_valid == 1'b0, "R1 valid in reset", longint'(rank_valid), 0);
        check(rank == '0, "R1 rank in reset", longint'(rank), 0);
        rst_n  = 1'b1;
        m_tok  = 1000;
        m_last = 0;
        @(negedge clk);
        check(rank_valid == 1'b0, "R1 valid after reset", longint'(rank_valid), 0);
    endtask

    // Full bucket, then debt that spills into the future (R1, R3, R4, R5).
    task automatic t_burst_debt;
        send_pkt(400, 0, 0, "R1 R4 first packet from full bucket");
        send_pkt(400, 0, 0, "R4 second within burst");
        send_pkt(400, 0, 50, "R3 R5 shortfall 200 at rate 4");
        send_pkt(100, 10, 75, "R5 debt carried, refill 40");
    endtask

    // Idle cycles leave the state and the rank alone (R8).
    task automatic t_idle;
        repeat (3) begin
            @(negedge clk);
            check(rank_valid == 1'b0, "R8 no strobe when idle", longint'(rank_valid), 0);
            check(rank == 32'd75, "R8 rank held", longint'(rank), 75);
        end
        send_pkt(4, 10, 76, "R8 bucket unchanged over idle");
    endtask

    // Long gap repays the debt and clips at the depth; round-up of one token (R2, R3).
    task automatic t_cap;
        send_pkt(1000, 100000, 100000, "R2 refill clipped to burst");
        send_pkt(1, 100000, 100001, "R3 round up of a single token");
    endtask

    // Different rate exponents (R9).
    task automatic t_rate;
        rate_shift = 4'd0;
        send_pkt(20, 100010, 100021, "R9 rate 1");
        rate_shift = 4'd5;
        send_pkt(100, 100012, 100014, "R9 rate 32");
        rate_shift = 4'd15;
        send_pkt(500, 3000000, 3000000, "R9 R2 widest shift over large gap");
    endtask

    // Packets on consecutive cycles (R7).
    task automatic t_back_to_back;
        rate_shift = 4'd1;
        @(negedge clk);
        pkt_valid = 1'b1;
        pkt_len   = LEN_W'(900);
        now       = 32'd3000001;
        m_rank    = model_pkt(900, 3000001);
        @(negedge clk);
        check(rank_valid == 1'b1, "R7 first strobe", longint'(rank_valid), 1);
        check(longint'(rank) == m_rank, "R7 first rank", longint'(rank), m_rank);
        pkt_len = LEN_W'(300);
        now     = 32'd3000002;
        m_rank  = model_pkt(300, 3000002);
        @(negedge clk);
        pkt_valid = 1'b0;
        check(rank_valid == 1'b1, "R7 second strobe", longint'(rank_valid), 1);
        check(longint'(rank) == m_rank, "R7 second rank uses updated state", longint'(rank), m_rank);
        @(negedge clk);
        check(rank_valid == 1'b0, "R7 strobe lasts one cycle", longint'(rank_valid), 0);
    endtask

    // Time base wrap (R6).
    task automatic t_wrap;
        rate_shift = 4'd0;
        send_pkt(1010, 64'hFFFF_FFF0, 64'hFFFF_FFFA, "R6 late in the time range");
        send_pkt(20, 5, 14, "R6 elapsed across wrap");
    endtask

    initial begin
        t_reset;
        t_burst_debt;
        t_idle;
        t_cap;
        t_rate;
        t_back_to_back;
        t_wrap;
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule